// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block lets a processor reach PCI configuration space through two memory-mapped windows of 4 KiB each. The processor first writes a 32-bit address register through the address window. It then reads or writes the data window, and each such access becomes one configuration cycle on a downstream request/acknowledge interface. The outgoing configuration address is built from the latched register and the low three bits of the data-window offset. The register supports three conventions, selected by its flag bits:

- **Pass-through:** bit 31 set.
- **Type-1:** bit 0 set.
- **Type-0:** both clear. The device is chosen by a one-hot bit in the upper register bits, and the block turns that bit into a binary device number.

Data crosses the block right-justified on the processor side and lane-aligned on the downstream side. When the block is built for a big-endian host, the bytes are reversed within the access length. The block also routes the interrupt pins of the downstream slots onto four shared lines using the usual rotation by device number.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the address register holds zero. A write through the address window (`cpu_win`=0) stores `cpu_wdata`. A read through it returns the stored value on `cpu_rdata`. Either access raises `cpu_rsp` one cycle after `cpu_req` and raises no downstream request.
- R2: With register bit 31 set, `cfg_addr` equals the register with bits [1:0] replaced by offset bits [1:0].
- R3: With bit 31 clear and bit 0 set, `cfg_addr` equals the register with bits [2:0] replaced by offset bits [2:0].
- R4: With bits 31 and 0 both clear, `cfg_addr` is built as follows:
  - bits [31:16] are zero;
  - bits [15:11] hold the position (11 to 30) of the lowest set register bit among bits [31:11];
  - bits [10:3] copy register bits [10:3];
  - bits [2:0] take offset bits [2:0].
- R5: In the R4 convention with register bits [31:11] all zero, no downstream request is raised. `cpu_rsp` rises one cycle after `cpu_req`. A read returns ones in the accessed bytes and zero above them. A write is discarded.
- R6: `cpu_size` codes 0, 1 and 2 select 1, 2 and 4 bytes. `cfg_be` is the mask of that many low bits, shifted left by offset bits [1:0]. Accesses are naturally aligned.
- R7: `cfg_wdata` is formed in three steps:
  - keep the accessed bytes of the right-justified `cpu_wdata`;
  - with BIG_ENDIAN=1, reverse their order within the access length;
  - shift left by 8 × offset[1:0].

  Unused lanes are zero.
- R8: Read data is formed in three steps:
  - shift `cfg_rdata` right by 8 × offset[1:0];
  - keep the accessed bytes;
  - with BIG_ENDIAN=1, reverse them within the access length.

  The result is returned right-justified on `cpu_rdata`, with zero above.
- R9: `cfg_req` rises one cycle after a data-window `cpu_req`. It stays high, with address, byte enables, direction and write data unchanged, until the cycle in which `cfg_ack` is high. `cpu_rsp` rises in the following cycle, together with the fall of `cfg_req`.
- R10: Pin p (0 to 3) of slot s drives `irq_out[(FIRST_SLOT + s + p) mod 4]`, the OR of all such pins, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access strobe from the processor |
| cpu_win | input | 1 | 0 selects the address window, 1 the data window |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_off | input | 3 | Low offset bits within the window |
| cpu_size | input | 2 | Access length code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_rsp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-justified read data, valid with `cpu_rsp` |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream direction, 1 = write |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Downstream byte lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Lane-aligned read data, valid with `cfg_ack` |
| dev_irq | input | NUM_SLOTS*4 | Interrupt pins, four per slot, slot-major |
| irq_out | output | 4 | Swizzled interrupt lines |

## Verification
The assertions take several things for granted about the inputs:
- the processor issues `cpu_req` only while no earlier access is pending;
- `cfg_ack` is raised only while `cfg_req` is high;
- accesses are naturally aligned, with size code 3 unused.

The stimulus sends one access at a time and waits for `cpu_rsp` before the next. It acknowledges only an observed request, after a varied delay of zero to three cycles. It pairs each size with offsets that are multiples of that size.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int unsigned CFG_AW     = 32;
    localparam int unsigned CFG_DW     = 32;
    localparam int unsigned CFG_BYTES  = CFG_DW / 8;
    localparam int unsigned OFF_W      = 3;
    localparam int unsigned T0_SLOT_LO = 11;
    localparam int unsigned SLOT_W     = $clog2(CFG_AW);
    localparam int unsigned INT_PINS   = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xl_state_e;

    typedef struct packed {
        xl_state_e               st;
        logic [CFG_AW-1:0]       areg;
        logic                    rsp;
        logic [CFG_DW-1:0]       rdata;
        logic                    req;
        logic                    we;
        logic [CFG_AW-1:0]       addr;
        logic [CFG_BYTES-1:0]    be;
        logic [CFG_DW-1:0]       wdata;
        logic [1:0]              size;
        logic [1:0]              lane;
        logic [INT_PINS-1:0]     irq;
    } xl_regs_t;
endpackage

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
    import cfgx_pkg::*;
(
    input  logic [CFG_AW-1:0] areg_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [CFG_AW-1:0] addr_o,
    output logic              no_dev_o
);
    logic [SLOT_W-1:0] slot;
    logic              found;

    // Lowest set bit among the one-hot device-select field wins.
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = int'(CFG_AW) - 1; i >= int'(T0_SLOT_LO); i--) begin
            if (areg_i[i]) begin
                found = 1'b1;
                slot  = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        addr_o   = '0;
        no_dev_o = 1'b0;
        if (areg_i[CFG_AW-1]) begin
            addr_o = {areg_i[CFG_AW-1:2], off_i[1:0]};
        end else if (areg_i[0]) begin
            addr_o = {areg_i[CFG_AW-1:3], off_i};
        end else begin
            addr_o[T0_SLOT_LO +: SLOT_W] = slot;
            addr_o[10:3]                 = areg_i[10:3];
            addr_o[2:0]                  = off_i;
            no_dev_o                     = ~found;
        end
    end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
    import cfgx_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [1:0]           size_i,
    input  logic [1:0]           lane_i,
    input  logic [CFG_DW-1:0]    wdata_i,
    input  logic [CFG_DW-1:0]    rdata_i,
    output logic [CFG_BYTES-1:0] be_o,
    output logic [CFG_DW-1:0]    wdata_o,
    output logic [CFG_DW-1:0]    rdata_o,
    output logic [CFG_DW-1:0]    rmask_o
);
    logic [2:0]           nb;
    logic [CFG_BYTES-1:0] bmask;
    logic [CFG_DW-1:0]    dmask;
    logic [CFG_DW-1:0]    wj;
    logic [CFG_DW-1:0]    rj;
    logic [CFG_DW-1:0]    wsw;
    logic [CFG_DW-1:0]    rsw;

    function automatic logic [CFG_DW-1:0] rev_bytes(input logic [CFG_DW-1:0] v,
                                                    input logic [2:0] n);
        logic [CFG_DW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(CFG_BYTES); i++) begin
            if (i < int'(n)) r[8*i +: 8] = v[8*(int'(n)-1-i) +: 8];
        end
        return r;
    endfunction

    always_comb begin
        case (size_i)
            2'd0:    nb = 3'd1;
            2'd1:    nb = 3'd2;
            default: nb = 3'd4;
        endcase
        for (int i = 0; i < int'(CFG_BYTES); i++) begin
            bmask[i]        = (i < int'(nb));
            dmask[8*i +: 8] = {8{bmask[i]}};
        end
    end

    assign wj = wdata_i & dmask;
    assign rj = (rdata_i >> {lane_i, 3'b000}) & dmask;

    generate
        if (BIG_ENDIAN) begin : g_big
            assign wsw = rev_bytes(wj, nb);
            assign rsw = rev_bytes(rj, nb);
        end else begin : g_little
            assign wsw = wj;
            assign rsw = rj;
        end
    endgenerate

    assign be_o    = bmask << lane_i;
    assign wdata_o = wsw << {lane_i, 3'b000};
    assign rdata_o = rsw;
    assign rmask_o = dmask;
endmodule

// File: rtl/cfgx_irq_swz.sv
module cfgx_irq_swz
    import cfgx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 4,
    parameter int unsigned FIRST_SLOT = 12
) (
    input  logic [NUM_SLOTS*INT_PINS-1:0] dev_irq_i,
    output logic [INT_PINS-1:0]           line_o
);
    localparam int unsigned NPIN = NUM_SLOTS * INT_PINS;

    function automatic logic [NPIN-1:0] pins_for_line(input int unsigned l);
        logic [NPIN-1:0] m;
        m = '0;
        for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
            for (int unsigned p = 0; p < INT_PINS; p++) begin
                if (((FIRST_SLOT + s + p) % INT_PINS) == l) m[s*INT_PINS + p] = 1'b1;
            end
        end
        return m;
    endfunction

    generate
        for (genvar l = 0; l < INT_PINS; l++) begin : g_line
            localparam logic [NPIN-1:0] MASK = pins_for_line(l);
            assign line_o[l] = |(dev_irq_i & MASK);
        end
    endgenerate
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
    import cfgx_pkg::*;
#(
    parameter bit          BIG_ENDIAN = 1'b1,
    parameter int unsigned NUM_SLOTS  = 4,
    parameter int unsigned FIRST_SLOT = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_win,
    input  logic                          cpu_we,
    input  logic [OFF_W-1:0]              cpu_off,
    input  logic [1:0]                    cpu_size,
    input  logic [CFG_DW-1:0]             cpu_wdata,
    output logic                          cpu_rsp,
    output logic [CFG_DW-1:0]             cpu_rdata,
    output logic                          cfg_req,
    output logic                          cfg_we,
    output logic [CFG_AW-1:0]             cfg_addr,
    output logic [CFG_BYTES-1:0]          cfg_be,
    output logic [CFG_DW-1:0]             cfg_wdata,
    input  logic                          cfg_ack,
    input  logic [CFG_DW-1:0]             cfg_rdata,
    input  logic [NUM_SLOTS*INT_PINS-1:0] dev_irq,
    output logic [INT_PINS-1:0]           irq_out
);
    xl_regs_t q, d;

    logic                 in_wait;
    logic [1:0]           size_sel;
    logic [1:0]           lane_sel;
    logic [CFG_AW-1:0]    map_addr;
    logic                 map_no_dev;
    logic [CFG_BYTES-1:0] lane_be;
    logic [CFG_DW-1:0]    lane_wdata;
    logic [CFG_DW-1:0]    lane_rdata;
    logic [CFG_DW-1:0]    lane_rmask;
    logic [INT_PINS-1:0]  irq_next;

    assign in_wait  = (q.st == ST_WAIT);
    assign size_sel = in_wait ? q.size : cpu_size;
    assign lane_sel = in_wait ? q.lane : cpu_off[1:0];

    cfgx_addr_map i_addr_map (
        .areg_i   (q.areg),
        .off_i    (cpu_off),
        .addr_o   (map_addr),
        .no_dev_o (map_no_dev)
    );

    cfgx_lane #(.BIG_ENDIAN(BIG_ENDIAN)) i_lane (
        .size_i  (size_sel),
        .lane_i  (lane_sel),
        .wdata_i (cpu_wdata),
        .rdata_i (cfg_rdata),
        .be_o    (lane_be),
        .wdata_o (lane_wdata),
        .rdata_o (lane_rdata),
        .rmask_o (lane_rmask)
    );

    cfgx_irq_swz #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) i_irq_swz (
        .dev_irq_i (dev_irq),
        .line_o    (irq_next)
    );

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        d.irq = irq_next;
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_win) begin
                        d.rsp = 1'b1;
                        if (cpu_we) begin
                            d.areg  = cpu_wdata;
                            d.rdata = '0;
                        end else begin
                            d.rdata = q.areg;
                        end
                    end else if (map_no_dev) begin
                        d.rsp   = 1'b1;
                        d.rdata = cpu_we ? '0 : lane_rmask;
                    end else begin
                        d.req   = 1'b1;
                        d.we    = cpu_we;
                        d.addr  = map_addr;
                        d.be    = lane_be;
                        d.wdata = cpu_we ? lane_wdata : '0;
                        d.size  = cpu_size;
                        d.lane  = cpu_off[1:0];
                        d.st    = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (cfg_ack) begin
                    d.req   = 1'b0;
                    d.rsp   = 1'b1;
                    d.rdata = q.we ? '0 : lane_rdata;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= xl_regs_t'('0);
        else        q <= d;
    end

    assign cpu_rsp   = q.rsp;
    assign cpu_rdata = q.rdata;
    assign cfg_req   = q.req;
    assign cfg_we    = q.we;
    assign cfg_addr  = q.addr;
    assign cfg_be    = q.be;
    assign cfg_wdata = q.wdata;
    assign irq_out   = q.irq;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker
    import cfgx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cpu_req,
    input logic                          cpu_win,
    input logic                          cpu_rsp,
    input logic                          cfg_req,
    input logic                          cfg_ack,
    input logic                          cfg_we,
    input logic [CFG_AW-1:0]             cfg_addr,
    input logic [CFG_BYTES-1:0]          cfg_be,
    input logic [CFG_DW-1:0]             cfg_wdata,
    input logic [NUM_SLOTS*INT_PINS-1:0] dev_irq,
    input logic [INT_PINS-1:0]           irq_out
);
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req);

    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_be)
                                && $stable(cfg_we) && $stable(cfg_wdata));

    p_rsp_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack |=> cpu_rsp && !cfg_req);

    p_no_rsp_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cpu_rsp);

    p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ($countones(cfg_be) == 1) || (cfg_be == 4'b0011)
                    || (cfg_be == 4'b1100) || (cfg_be == 4'b1111));

    p_addr_window_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_win && !cfg_req |=> cpu_rsp && !cfg_req);

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq == '0 |=> irq_out == '0);
endmodule

bind cfg_addr_xlate cfgx_checker #(.NUM_SLOTS(NUM_SLOTS)) i_cfgx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_win   (cpu_win),
    .cpu_rsp   (cpu_rsp),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .dev_irq   (dev_irq),
    .irq_out   (irq_out)
);

// File: tb/test_cfg_addr_xlate.sv
`timescale 1ns/1ps
module test_cfg_addr_xlate;
    localparam int NS = 4;
    localparam int FS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_win = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_off = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rsp;
    logic [31:0] cpu_rdata;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [NS*4-1:0] dev_irq = '0;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] areg_m = '0;
    logic [3:0]  exp_irq_q = '0;

    always #2.5 clk = ~clk;

    cfg_addr_xlate i_cfg_addr_xlate (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_win(cpu_win), .cpu_we(cpu_we),
        .cpu_off(cpu_off), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rsp(cpu_rsp),
        .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .dev_irq(dev_irq), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] m_swap(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] m_addr(input logic [31:0] r, input logic [2:0] o);
        int slot = 0;
        if (r[31]) return (r & ~32'h3) | {30'd0, o[1:0]};
        if (r[0])  return (r & ~32'h7) | {29'd0, o};
        for (int i = 31; i >= 11; i--) if (r[i]) slot = i;
        return (r & 32'h0000_07F8) | {29'd0, o} | (32'(slot) << 11);
    endfunction

    function automatic bit m_nodev(input logic [31:0] r);
        return !r[31] && !r[0] && (r[31:11] == 21'd0);
    endfunction

    function automatic logic [3:0] m_irq(input logic [NS*4-1:0] pins);
        logic [3:0] o = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (pins[s*4+p]) o[(FS + s + p) % 4] = 1'b1;
        return o;
    endfunction

    // Interrupt reference: sampled every rising edge, compared every falling edge.
    always @(posedge clk) exp_irq_q = rst_n ? m_irq(dev_irq) : 4'd0;
    always @(negedge clk) if (rst_n && !finished) chk("R10 irq swizzle", {28'd0, irq_out}, {28'd0, exp_irq_q});

    task automatic addr_acc(input bit we, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1; cpu_win = 0; cpu_we = we; cpu_size = 2'd2; cpu_off = 3'd0; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        chk("R1 address-window response", {30'd0, cpu_rsp, cfg_req}, 32'd2);
        if (we) areg_m = wd;
        else    chk("R1 address register readback", cpu_rdata, areg_m);
    endtask

    task automatic data_acc(input bit we, input logic [2:0] off, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [31:0] dn, input int dly,
                            input string tag);
        int n = nbytes(sz);
        logic [31:0] m = (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 32'd1);
        logic [31:0] ea = m_addr(areg_m, off);
        @(negedge clk);
        cpu_req = 1; cpu_win = 1; cpu_we = we; cpu_off = off; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        if (m_nodev(areg_m)) begin
            chk({tag, " R5 no-device response"}, {30'd0, cpu_rsp, cfg_req}, 32'd2);
            if (!we) chk({tag, " R5 no-device read ones"}, cpu_rdata, m);
        end else begin
            chk({tag, " R9 request raised"}, {30'd0, cfg_req, cpu_rsp}, 32'd2);
            chk({tag, " R2 R3 R4 address"}, cfg_addr, ea);
            chk({tag, " R6 byte enables"}, {28'd0, cfg_be},
                (((32'd1 << n) - 32'd1) << off[1:0]) & 32'hF);
            chk({tag, " R9 direction"}, {31'd0, cfg_we}, {31'd0, we});
            if (we) chk({tag, " R7 write data"}, cfg_wdata, m_swap(wd & m, n) << (8*off[1:0]));
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                chk({tag, " R9 request held"}, {31'd0, cfg_req}, 32'd1);
                chk({tag, " R9 address stable"}, cfg_addr, ea);
            end
            cfg_ack = 1; cfg_rdata = dn;
            @(negedge clk);
            cfg_ack = 0; cfg_rdata = 32'hDEAD_BEEF;
            chk({tag, " R9 response after ack"}, {30'd0, cpu_rsp, cfg_req}, 32'd2);
            if (!we) chk({tag, " R8 read data"}, cpu_rdata, m_swap((dn >> (8*off[1:0])) & m, n));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {30'd0, cpu_rsp, cfg_req}, 32'd0);
        chk("R10 reset irq", {28'd0, irq_out}, 32'd0);
        rst_n = 1;
        addr_acc(0, 32'd0);
        dev_irq = 16'h0001;
        // Pass-through convention
        addr_acc(1, 32'h8000_1234);
        addr_acc(0, 32'd0);
        data_acc(0, 3'd2, 2'd0, 32'd0, 32'h00AB_0000, 0, "R2 byte read");
        data_acc(1, 3'd4, 2'd2, 32'hCAFE_F00D, 32'd0, 2, "R2 word write");
        dev_irq = 16'h8421;
        // Type-1 convention
        addr_acc(1, 32'h0000_5A05);
        data_acc(1, 3'd6, 2'd1, 32'hFFFF_1234, 32'd0, 1, "R3 half write");
        data_acc(0, 3'd5, 2'd0, 32'd0, 32'h0000_7700, 3, "R3 byte read");
        dev_irq = 16'hF0F0;
        // Type-0 convention
        addr_acc(1, 32'h0010_1350);
        data_acc(0, 3'd4, 2'd2, 32'd0, 32'h1122_3344, 0, "R4 lowest slot bit");
        addr_acc(1, 32'h0000_0800);
        data_acc(1, 3'd0, 2'd2, 32'hAABB_CCDD, 32'd0, 1, "R4 slot 11");
        addr_acc(1, 32'h4000_0000);
        data_acc(0, 3'd1, 2'd0, 32'd0, 32'h0000_9900, 2, "R4 slot 30");
        data_acc(0, 3'd2, 2'd1, 32'd0, 32'h5566_7788, 0, "R8 half read");
        dev_irq = 16'h0000;
        // No device selected
        addr_acc(1, 32'h0000_0700);
        data_acc(0, 3'd2, 2'd1, 32'd0, 32'd0, 0, "R5 read");
        data_acc(1, 3'd0, 2'd2, 32'h1234_5678, 32'd0, 0, "R5 write");
        data_acc(0, 3'd0, 2'd2, 32'd0, 32'd0, 0, "R5 word read");
        addr_acc(0, 32'd0);
        dev_irq = 16'h1248;
        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule